// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors notify each other over a small set of channels without moving any payload. Every channel carries one "occupied" flag per direction. A sender raises its own flag to post, and the receiver drops that flag to acknowledge. The message body lives in memory outside the block.

Each processor has a register port that completes in one cycle. Through that port it reaches a bank of four registers: control, mask, set/clear and status. Two read-only identification words sit near the top of the address map. Each processor gets two level-sensitive interrupts. The receive interrupt says the peer has posted on an unmasked channel. The transmit interrupt says one of the processor's own unmasked channels is free again.

A typical exchange runs like this. The sender posts on a channel and unmasks the transmit interrupt for that channel. The receiver's interrupt handler reads the sender's status word and services the channel, then acknowledges it. The acknowledge frees the channel, which raises the sender's transmit interrupt.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, all occupied flags are 0 and both interrupt enables are 0. Every mask bit reads 1, and all four interrupt outputs are low.
- R2: Addresses are in bytes and bits 1:0 are ignored. Processor p's bank starts at 0x10*p. Inside a bank, control is at +0x0, mask at +0x4, set/clear at +0x8 and status at +0xC. Either port can read both banks. A port's writes take effect only in its own bank, and a write to the peer's bank changes nothing.
- R3: A 1 written to bit 16+n of a processor's set/clear register sets that processor's outgoing flag for channel n. Bit n of its status register reads 1 while that flag is set. Status bits 31:NUM_CH read 0.
- R4: A 1 written to bit n of a processor's set/clear register clears the peer's outgoing flag for channel n. Bits written as 0 have no effect.
- R5: The set/clear register always reads 0.
- R6: Suppose that, in one cycle, the owner sets a flag and the peer clears the same flag. The flag ends up set. Writes in one cycle that touch different flags both take effect.
- R7: A processor's receive interrupt is high exactly when its control bit 0 is 1 and, for some channel n, the peer's flag n is set while its own mask bit n is 0.
- R8: A processor's transmit interrupt is high exactly when its control bit 16 is 1 and, for some implemented channel n, its own flag n is clear while its own mask bit 16+n is 0.
- R9: Control reads back only bits 0 and 16, and all other bits read 0. Mask bits for implemented channels read back as written. Mask bits for channels at or above NUM_CH read 1.
- R10: The word at 0x3F0 reads NUM_CH in bits 7:0. The word at 0x3F4 reads the minor revision in bits 3:0 and the major revision in bits 7:4. Every other bit of these two words reads 0, and any address that maps to nothing reads 0.
- R11: Read data is combinational. It is valid in the cycle where the request is high and the write strobe is low, and it is 0 at all other times.
- R12: Flags for channels at or above NUM_CH cannot be set and never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p0_req_i | input | 1 | Processor 0 access request |
| p0_we_i | input | 1 | Processor 0 write strobe |
| p0_addr_i | input | ADDR_W | Processor 0 byte address |
| p0_wdata_i | input | 32 | Processor 0 write data |
| p0_rdata_o | output | 32 | Processor 0 read data |
| p0_rx_irq_o | output | 1 | Processor 0 receive interrupt |
| p0_tx_irq_o | output | 1 | Processor 0 transmit interrupt |
| p1_req_i | input | 1 | Processor 1 access request |
| p1_we_i | input | 1 | Processor 1 write strobe |
| p1_addr_i | input | ADDR_W | Processor 1 byte address |
| p1_wdata_i | input | 32 | Processor 1 write data |
| p1_rdata_o | output | 32 | Processor 1 read data |
| p1_rx_irq_o | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq_o | output | 1 | Processor 1 transmit interrupt |

## Verification
Two events can land on the same flag in one cycle: the owner posting on a channel and the peer acknowledging that channel. The bench drives both ports on the same clock edge. In one case both writes name the same channel, and the flag must stay set. In the other they name different channels, and both must take effect. The bench then reads the owner's status word and compares it with the value expected from the post-wins rule.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int unsigned NPROC      = 2;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned RX_EN_BIT  = 0;
  localparam int unsigned TX_EN_BIT  = 16;
  // word addresses (byte address >> 2) of shared identification registers
  localparam int unsigned CFG_WORD   = 'h0FC;
  localparam int unsigned VER_WORD   = 'h0FD;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STAT   = 2'd3
  } bank_reg_e;
endpackage

// File: rtl/mbox_bank.sv
`timescale 1ns/1ps
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  bank_reg_e         sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] own_flags_i,
  input  logic [NUM_CH-1:0] peer_flags_i,
  output logic [NUM_CH-1:0] set_o,
  output logic [NUM_CH-1:0] clr_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] mask_rd_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);
  logic              rx_en_q, tx_en_q;
  logic [NUM_CH-1:0] rx_mask_q, tx_mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_mask_q <= '1;
      tx_mask_q <= '1;
    end else if (wr_i) begin
      if (sel_i == REG_CTRL) begin
        rx_en_q <= wdata_i[RX_EN_BIT];
        tx_en_q <= wdata_i[TX_EN_BIT];
      end
      if (sel_i == REG_MASK) begin
        rx_mask_q <= wdata_i[NUM_CH-1:0];
        tx_mask_q <= wdata_i[HALF_W +: NUM_CH];
      end
    end
  end

  // high half posts own flags, low half acknowledges peer flags
  assign set_o = (wr_i && sel_i == REG_SETCLR) ? wdata_i[HALF_W +: NUM_CH] : '0;
  assign clr_o = (wr_i && sel_i == REG_SETCLR) ? wdata_i[NUM_CH-1:0]       : '0;

  always_comb begin
    ctrl_rd_o            = '0;
    ctrl_rd_o[RX_EN_BIT] = rx_en_q;
    ctrl_rd_o[TX_EN_BIT] = tx_en_q;
    mask_rd_o                      = '1;
    mask_rd_o[NUM_CH-1:0]          = rx_mask_q;
    mask_rd_o[HALF_W +: NUM_CH]    = tx_mask_q;
  end

  assign rx_irq_o = rx_en_q & |(peer_flags_i & ~rx_mask_q);
  assign tx_irq_o = tx_en_q & |(~own_flags_i & ~tx_mask_q);

  // R7
  rx_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (|peer_flags_i));
  // R8
  tx_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> !(&own_flags_i));
  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == REG_SETCLR) |=> ($stable(ctrl_rd_o) && $stable(mask_rd_o)));
endmodule

// File: rtl/mbox_flags.sv
`timescale 1ns/1ps
module mbox_flags
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NPROC-1:0][NUM_CH-1:0] set_i,
  input  logic [NPROC-1:0][NUM_CH-1:0] clr_i,
  output logic [NPROC-1:0][NUM_CH-1:0] flags_o
);
  logic [NPROC-1:0][NUM_CH-1:0] flag_q;

  // clear from the peer applies first, so a same-cycle post survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      for (int p = 0; p < NPROC; p++) begin
        flag_q[p] <= (flag_q[p] & ~clr_i[NPROC-1-p]) | set_i[p];
      end
    end
  end

  assign flags_o = flag_q;

  for (genvar p = 0; p < NPROC; p++) begin : g_chk
    localparam int unsigned PEER = NPROC - 1 - p;
    // R6
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_i[p]) |=> ((flag_q[p] & $past(set_i[p])) == $past(set_i[p])));
    // R4
    peer_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(clr_i[PEER] & ~set_i[p])) |=> ((flag_q[p] & $past(clr_i[PEER] & ~set_i[p])) == '0));
    // R3
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(|set_i[p]) && !(|clr_i[PEER])) |=> $stable(flag_q[p]));
  end
endmodule

// File: rtl/mbox_flag_ctrl.sv
`timescale 1ns/1ps
module mbox_flag_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_CH    = 16,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned VER_MAJOR = 1,
  parameter int unsigned VER_MINOR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              p0_req_i,
  input  logic              p0_we_i,
  input  logic [ADDR_W-1:0] p0_addr_i,
  input  logic [31:0]       p0_wdata_i,
  output logic [31:0]       p0_rdata_o,
  output logic              p0_rx_irq_o,
  output logic              p0_tx_irq_o,
  input  logic              p1_req_i,
  input  logic              p1_we_i,
  input  logic [ADDR_W-1:0] p1_addr_i,
  input  logic [31:0]       p1_wdata_i,
  output logic [31:0]       p1_rdata_o,
  output logic              p1_rx_irq_o,
  output logic              p1_tx_irq_o
);
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned BANK_LSB = 4;

  logic [NPROC-1:0]              req_w, we_w, rx_irq_w, tx_irq_w;
  logic [NPROC-1:0][ADDR_W-1:0]  addr_w;
  logic [NPROC-1:0][DATA_W-1:0]  wdata_w, ctrl_rd_w, mask_rd_w, rdata_w;
  logic [NPROC-1:0][NUM_CH-1:0]  set_w, clr_w, flags_w;

  assign req_w   = {p1_req_i, p0_req_i};
  assign we_w    = {p1_we_i, p0_we_i};
  assign addr_w  = {p1_addr_i, p0_addr_i};
  assign wdata_w = {p1_wdata_i, p0_wdata_i};

  mbox_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .flags_o (flags_w)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_port
    localparam int unsigned PEER = NPROC - 1 - p;
    logic              bank_hit, own_wr;
    logic              bank_idx;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] rd_d;

    assign word     = addr_w[p][ADDR_W-1:2];
    assign bank_hit = (addr_w[p][ADDR_W-1:BANK_LSB+1] == '0);
    assign bank_idx = addr_w[p][BANK_LSB];
    assign own_wr   = req_w[p] & we_w[p] & bank_hit & (bank_idx == 1'(p));

    mbox_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (own_wr),
      .sel_i        (bank_reg_e'(addr_w[p][3:2])),
      .wdata_i      (wdata_w[p]),
      .own_flags_i  (flags_w[p]),
      .peer_flags_i (flags_w[PEER]),
      .set_o        (set_w[p]),
      .clr_o        (clr_w[p]),
      .ctrl_rd_o    (ctrl_rd_w[p]),
      .mask_rd_o    (mask_rd_w[p]),
      .rx_irq_o     (rx_irq_w[p]),
      .tx_irq_o     (tx_irq_w[p])
    );

    always_comb begin
      rd_d = '0;
      if (req_w[p] && !we_w[p]) begin
        if (bank_hit) begin
          unique case (bank_reg_e'(addr_w[p][3:2]))
            REG_CTRL:   rd_d = ctrl_rd_w[bank_idx];
            REG_MASK:   rd_d = mask_rd_w[bank_idx];
            REG_SETCLR: rd_d = '0;
            REG_STAT:   rd_d = DATA_W'(flags_w[bank_idx]);
            default:    rd_d = '0;
          endcase
        end else if (word == WORD_W'(CFG_WORD)) begin
          rd_d = DATA_W'(NUM_CH);
        end else if (word == WORD_W'(VER_WORD)) begin
          rd_d = {24'd0, 4'(VER_MAJOR), 4'(VER_MINOR)};
        end
      end
    end
    assign rdata_w[p] = rd_d;
  end

  assign p0_rdata_o  = rdata_w[0];
  assign p1_rdata_o  = rdata_w[1];
  assign p0_rx_irq_o = rx_irq_w[0];
  assign p1_rx_irq_o = rx_irq_w[1];
  assign p0_tx_irq_o = tx_irq_w[0];
  assign p1_tx_irq_o = tx_irq_w[1];

  logic unused_ok;
  assign unused_ok = ^{p0_addr_i[1:0], p1_addr_i[1:0]};

  // R11
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!p0_req_i || p0_we_i) |-> (p0_rdata_o == '0));
  // R7
  p1_rx_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p1_rx_irq_o |-> (|flags_w[0]));
endmodule

// File: tb/mbox_flag_ctrl_bench.sv
`timescale 1ns/1ps
module mbox_flag_ctrl_bench;
  localparam int unsigned NUM_CH = 12;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned VMAJ   = 2;
  localparam int unsigned VMIN   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              req   [2];
  logic              we    [2];
  logic [ADDR_W-1:0] addr  [2];
  logic [31:0]       wdata [2];
  logic [31:0]       rdata [2];
  logic              rx_irq[2];
  logic              tx_irq[2];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  mbox_flag_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN))
  u_mbox_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .p0_req_i(req[0]), .p0_we_i(we[0]), .p0_addr_i(addr[0]), .p0_wdata_i(wdata[0]),
    .p0_rdata_o(rdata[0]), .p0_rx_irq_o(rx_irq[0]), .p0_tx_irq_o(tx_irq[0]),
    .p1_req_i(req[1]), .p1_we_i(we[1]), .p1_addr_i(addr[1]), .p1_wdata_i(wdata[1]),
    .p1_rdata_o(rdata[1]), .p1_rx_irq_o(rx_irq[1]), .p1_tx_irq_o(tx_irq[1])
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic bus_wr(input int p, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req[p] = 1'b1; we[p] = 1'b1; addr[p] = a; wdata[p] = d;
    @(negedge clk);
    req[p] = 1'b0; we[p] = 1'b0;
  endtask

  task automatic bus_wr2(input logic [ADDR_W-1:0] a0, input logic [31:0] d0,
                         input logic [ADDR_W-1:0] a1, input logic [31:0] d1);
    @(negedge clk);
    req[0] = 1'b1; we[0] = 1'b1; addr[0] = a0; wdata[0] = d0;
    req[1] = 1'b1; we[1] = 1'b1; addr[1] = a1; wdata[1] = d1;
    @(negedge clk);
    req[0] = 1'b0; we[0] = 1'b0; req[1] = 1'b0; we[1] = 1'b0;
  endtask

  task automatic bus_rd(input int p, input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req[p] = 1'b1; we[p] = 1'b0; addr[p] = a;
    #1;
    d = rdata[p];
    req[p] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R11 idle read data", rdata[0], 32'h0);
    chk("R1 irqs after reset", {28'd0, rx_irq[0], tx_irq[0], rx_irq[1], tx_irq[1]}, 32'h0);
    bus_rd(0, 10'h000, d); chk("R1 p0 ctrl reset", d, 32'h0);
    bus_rd(0, 10'h004, d); chk("R1 p0 mask reset", d, 32'hFFFF_FFFF);
    bus_rd(1, 10'h014, d); chk("R1 p1 mask reset", d, 32'hFFFF_FFFF);
    bus_rd(0, 10'h00C, d); chk("R1 p0 status reset", d, 32'h0);
  endtask

  task automatic t_ident;
    logic [31:0] d;
    bus_rd(0, 10'h3F0, d); chk("R10 channel count", d, 32'd12);
    bus_rd(1, 10'h3F4, d); chk("R10 version", d, 32'h23);
    bus_rd(0, 10'h100, d); chk("R10 unmapped read", d, 32'h0);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] d;
    bus_wr(0, 10'h000, 32'hFFFF_FFFF);
    bus_rd(0, 10'h000, d); chk("R9 ctrl readback", d, 32'h0001_0001);
    bus_wr(0, 10'h004, 32'h0);
    bus_rd(0, 10'h004, d); chk("R9 mask readback", d, 32'hF000_F000);
    @(negedge clk);
    chk("R8 p0 tx irq all free", {31'd0, tx_irq[0]}, 32'd1);
    chk("R7 p0 rx irq idle", {31'd0, rx_irq[0]}, 32'd0);
  endtask

  task automatic t_post;
    logic [31:0] d;
    bus_wr(0, 10'h008, 32'h1 << 19);
    bus_rd(0, 10'h00C, d); chk("R3 p0 status after post", d, 32'h8);
    bus_rd(1, 10'h00C, d); chk("R2 p1 reads p0 status", d, 32'h8);
    bus_rd(0, 10'h008, d); chk("R5 set/clear reads zero", d, 32'h0);
    @(negedge clk);
    chk("R7 p1 rx irq disabled", {31'd0, rx_irq[1]}, 32'd0);
    bus_wr(1, 10'h010, 32'h1);
    bus_wr(1, 10'h014, 32'hFFFF_0000);
    @(negedge clk);
    chk("R7 p1 rx irq raised", {31'd0, rx_irq[1]}, 32'd1);
    bus_wr(1, 10'h014, 32'hFFFF_0008);
    @(negedge clk);
    chk("R7 p1 rx irq masked", {31'd0, rx_irq[1]}, 32'd0);
    bus_wr(1, 10'h014, 32'hFFFF_0000);
    @(negedge clk);
    chk("R8 p1 tx irq disabled", {31'd0, tx_irq[1]}, 32'd0);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    bus_wr(1, 10'h018, 32'h0);
    bus_rd(0, 10'h00C, d); chk("R4 zero write no effect", d, 32'h8);
    bus_wr(1, 10'h018, 32'h8);
    bus_rd(0, 10'h00C, d); chk("R4 ack clears peer flag", d, 32'h0);
    @(negedge clk);
    chk("R7 p1 rx irq after ack", {31'd0, rx_irq[1]}, 32'd0);
  endtask

  task automatic t_peer_bank;
    logic [31:0] d;
    bus_wr(1, 10'h000, 32'h0);
    bus_rd(0, 10'h000, d); chk("R2 peer ctrl write ignored", d, 32'h0001_0001);
    bus_wr(0, 10'h014, 32'hFFFF_FFFF);
    bus_rd(1, 10'h014, d); chk("R2 peer mask write ignored", d, 32'hFFFF_F000);
  endtask

  task automatic t_tx_free;
    logic [31:0] d;
    bus_wr(0, 10'h008, 32'h0FFF_0000);
    bus_rd(0, 10'h00C, d); chk("R3 all channels posted", d, 32'hFFF);
    @(negedge clk);
    chk("R12 no tx irq from absent channels", {31'd0, tx_irq[0]}, 32'd0);
    bus_wr(0, 10'h008, 32'h1 << 29);
    bus_rd(0, 10'h00C, d); chk("R12 absent channel not set", d, 32'hFFF);
    bus_wr(1, 10'h018, 32'h1 << 5);
    bus_rd(0, 10'h00C, d); chk("R4 ack channel 5", d, 32'hFDF);
    chk("R8 tx irq on free", {31'd0, tx_irq[0]}, 32'd1);
    bus_wr(0, 10'h004, 32'h0020_0000);
    bus_rd(0, 10'h004, d); chk("R9 mask with absent bits", d, 32'hF020_F000);
    chk("R8 tx irq masked", {31'd0, tx_irq[0]}, 32'd0);
    bus_wr(0, 10'h004, 32'h0);
    @(negedge clk);
    chk("R8 tx irq unmasked", {31'd0, tx_irq[0]}, 32'd1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    bus_wr2(10'h008, 32'h1 << 23, 10'h018, 32'h1 << 7);
    bus_rd(0, 10'h00C, d); chk("R6 post beats ack same channel", d, 32'hFDF);
    bus_wr2(10'h008, 32'h1 << 21, 10'h018, 32'h1 << 2);
    bus_rd(0, 10'h00C, d); chk("R6 post and ack different channels", d, 32'hFFB);
    @(negedge clk);
    chk("R7 p1 rx irq with posts", {31'd0, rx_irq[1]}, 32'd1);
    bus_wr(1, 10'h010, 32'h0);
    @(negedge clk);
    chk("R7 p1 rx irq enable off", {31'd0, rx_irq[1]}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      req[i] = 1'b0; we[i] = 1'b0; addr[i] = '0; wdata[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ident();
    t_ctrl_mask();
    t_post();
    t_ack();
    t_peer_bank();
    t_tx_free();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule